// File: doc/BRIEF.md
# Channel-Mapped Priority Interrupt Router

This block accepts a vector of system interrupt sources that are already enabled and pending. It gives each source a priority channel from 0 to 31, held as one programmable byte per source. A lower channel number means a higher priority. Channels 0 and 1 belong to the fast-interrupt host output, and channels 2 to 31 belong to the normal-interrupt host output.

For each host, a combinational arbiter finds the active source with the lowest channel. When two or more sources share that channel, the lower source number wins. The result is readable as a winner word holding a valid flag and the source number.

Each host output also has its own enable bit, and there is one global enable. The host output lines are registered once. Software reaches the map, the enables and the winner words through a simple word-addressed read/write port.

Top module: `chan_prio_router`

## Requirements
- R1: After reset every map byte is 0x0F, so each map word reads 0x0F0F0F0F. The global enable and both host enables are 0, both host outputs are low, and both winner words read 0.
- R2: Map word n sits at address 16+n and covers sources 4n to 4n+3. Byte k (bits 8k+7 to 8k) belongs to source 4n+k. The whole word reads back as written, but only the low 5 bits of each byte select the channel.
- R3: An active source on channel 0 or 1 competes only for the fast host. An active source on channels 2 to 31 competes only for the normal host.
- R4: Within a host, the active source with the lowest channel wins. Among sources on the same channel, the lowest source number wins.
- R5: The winner word reads at address 3 for the fast host and at address 4 for the normal host. Bit 31 is the valid flag and bits 7 to 0 hold the source number. The word is 0 when no source competes for that host. It follows the current source inputs in the same cycle.
- R6: Writing data 0 to address 1 sets the fast host enable, and writing data 1 sets the normal host enable. The same data values written to address 2 clear the matching enable. Any other data value written to address 1 or 2 changes nothing. Address 5 reads the enables as bit 0 (fast) and bit 1 (normal).
- R7: Bit 0 at address 0 is the global enable. It reads back at the same position.
- R8: A host output goes high on the clock edge after three conditions hold together: the global enable is 1, that host's enable is 1, and its winner is valid. The output goes low on the edge after any of the three is lost.
- R9: A write to an address not listed above changes no state. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_active | input | NUM_SRC | Enabled, pending system sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fast_irq | output | 1 | Fast host interrupt, registered |
| norm_irq | output | 1 | Normal host interrupt, registered |

## Verification
Winner words and all register reads are combinational. A read therefore reflects a new source pattern in the same cycle, while a register write takes effect at the next rising edge. The host output lines trail their conditions by exactly one rising edge.

The bench drives inputs at the falling edge and reads registers one time unit later. It then checks the host lines at the following falling edge, after the single registering edge has passed.

// File: rtl/chan_prio_pkg.sv
package chan_prio_pkg;
  localparam int CHAN_W     = 5;
  localparam int A_GLOBAL   = 0;
  localparam int A_HEN_SET  = 1;
  localparam int A_HEN_CLR  = 2;
  localparam int A_WIN_FAST = 3;
  localparam int A_WIN_NORM = 4;
  localparam int A_HEN_STAT = 5;
  localparam int A_MAP_BASE = 16;
  localparam int N_HOSTS    = 2;
  typedef logic [CHAN_W-1:0] chan_t;

  // channel of source s taken from a flat byte-per-source map
  function automatic chan_t chan_of(input logic [255:0] map, input int s);
    return map[s*8 +: CHAN_W];
  endfunction
endpackage

// File: rtl/chan_map_regs.sv
module chan_map_regs
  import chan_prio_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [N_HOSTS-1:0][31:0] win_word,
  output logic                    glob_en,
  output logic [N_HOSTS-1:0]      host_en,
  output logic [NUM_SRC*8-1:0]    map_flat
);
  localparam int NUM_MAP = NUM_SRC / 4;

  int a;
  assign a = int'(reg_addr);

  logic set_fast_ev, clr_fast_ev, set_norm_ev, clr_norm_ev;
  assign set_fast_ev = reg_wr && a == A_HEN_SET && reg_wdata == 32'd0;
  assign set_norm_ev = reg_wr && a == A_HEN_SET && reg_wdata == 32'd1;
  assign clr_fast_ev = reg_wr && a == A_HEN_CLR && reg_wdata == 32'd0;
  assign clr_norm_ev = reg_wr && a == A_HEN_CLR && reg_wdata == 32'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      host_en  <= '0;
      map_flat <= {NUM_MAP{32'h0F0F_0F0F}};
    end else begin
      if (reg_wr && a == A_GLOBAL) glob_en <= reg_wdata[0];
      if (set_fast_ev) host_en[0] <= 1'b1;
      if (set_norm_ev) host_en[1] <= 1'b1;
      if (clr_fast_ev) host_en[0] <= 1'b0;
      if (clr_norm_ev) host_en[1] <= 1'b0;
      for (int n = 0; n < NUM_MAP; n++)
        if (reg_wr && a == A_MAP_BASE + n) map_flat[n*32 +: 32] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = 32'd0;
    if (a == A_GLOBAL)   reg_rdata = {31'd0, glob_en};
    if (a == A_WIN_FAST) reg_rdata = win_word[0];
    if (a == A_WIN_NORM) reg_rdata = win_word[1];
    if (a == A_HEN_STAT) reg_rdata = {30'd0, host_en};
    for (int n = 0; n < NUM_MAP; n++)
      if (a == A_MAP_BASE + n) reg_rdata = map_flat[n*32 +: 32];
  end

  // R6: indexed set / clear reach the enable bits on the next edge
  a_r6_set_fast: assert property (@(posedge clk) disable iff (!rst_n)
    set_fast_ev |=> host_en[0]);
  a_r6_set_norm: assert property (@(posedge clk) disable iff (!rst_n)
    set_norm_ev |=> host_en[1]);
  a_r6_clr_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_norm_ev && !set_norm_ev) |=> !host_en[1]);
  // R6: other index values leave the enables alone
  a_r6_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_fast_ev || set_norm_ev || clr_fast_ev || clr_norm_ev) |=> $stable(host_en));
endmodule

// File: rtl/host_arbiter.sv
module host_arbiter
  import chan_prio_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int CH_LO   = 0,
  parameter int CH_HI   = 1,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_active,
  input  logic [NUM_SRC*8-1:0] map_flat,
  output logic                 win_vld,
  output logic [SRC_W-1:0]     win_src,
  output chan_t                win_chan
);
  function automatic logic in_range(input chan_t c);
    return int'(c) >= CH_LO && int'(c) <= CH_HI;
  endfunction

  // per-source channel brought out for the checks
  chan_t src_chan [NUM_SRC];
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_ch
    assign src_chan[s] = map_flat[s*8 +: CHAN_W];
  end

  // ascending scan with strict compare: lower channel, then lower source
  always_comb begin
    win_vld  = 1'b0;
    win_src  = '0;
    win_chan = '1;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_active[s] && in_range(src_chan[s]) &&
          (!win_vld || src_chan[s] < win_chan)) begin
        win_vld  = 1'b1;
        win_src  = SRC_W'(s);
        win_chan = src_chan[s];
      end
    end
    if (!win_vld) win_chan = '0;
  end

  // R3: a winner always lies in this host's channel range
  a_r3_win_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> in_range(win_chan));
  // R4: the winner is an active source
  a_r4_win_active: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> src_active[win_src]);
  // R5: no active source means no valid winner
  a_r5_idle_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (src_active == '0) |-> !win_vld);
endmodule

// File: rtl/chan_prio_router.sv
module chan_prio_router
  import chan_prio_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int ADDR_W    = 6,
  parameter int FAST_LAST = 1,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_active,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               fast_irq,
  output logic               norm_irq
);
  logic                     glob_en;
  logic [N_HOSTS-1:0]       host_en;
  logic [NUM_SRC*8-1:0]     map_flat;
  logic [N_HOSTS-1:0]       win_vld;
  logic [N_HOSTS-1:0][31:0] win_word;
  logic [N_HOSTS-1:0]       irq_q;
  logic [N_HOSTS-1:0]       irq_want;

  chan_map_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_word(win_word),
    .glob_en(glob_en), .host_en(host_en), .map_flat(map_flat)
  );

  for (genvar h = 0; h < N_HOSTS; h++) begin : g_host
    localparam int LO = (h == 0) ? 0 : FAST_LAST + 1;
    localparam int HI = (h == 0) ? FAST_LAST : (1 << CHAN_W) - 1;
    logic [SRC_W-1:0] w_src;
    chan_t            w_chan;
    host_arbiter #(.NUM_SRC(NUM_SRC), .CH_LO(LO), .CH_HI(HI)) u_arb (
      .clk(clk), .rst_n(rst_n), .src_active(src_active), .map_flat(map_flat),
      .win_vld(win_vld[h]), .win_src(w_src), .win_chan(w_chan)
    );
    assign win_word[h] = {win_vld[h], {(31-SRC_W){1'b0}}, w_src};
    assign irq_want[h] = glob_en && host_en[h] && win_vld[h];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_want;
  end

  assign fast_irq = irq_q[0];
  assign norm_irq = irq_q[1];

  // R8: each host line follows its three conditions one edge later
  a_r8_fast_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fast_irq == $past(glob_en && host_en[0] && win_vld[0]));
  a_r8_norm_follows: assert property (@(posedge clk) disable iff (!rst_n)
    norm_irq == $past(glob_en && host_en[1] && win_vld[1]));
  // R3: a fast and a normal winner can never be the same source
  a_r3_hosts_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld == 2'b11) |-> (win_word[0][SRC_W-1:0] != win_word[1][SRC_W-1:0]));
endmodule

// File: tb/chan_prio_router_test.sv
module chan_prio_router_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] V = 32'h8000_0000;
  // {src_active, fast winner word, normal winner word}
  localparam logic [79:0] VEC [9] = '{
    {16'h0000, 32'd0,       32'd0},
    {16'h0001, 32'd0,       V | 32'd0},
    {16'h0003, V | 32'd1,   V | 32'd0},
    {16'h010A, V | 32'd3,   32'd0},
    {16'h1054, 32'd0,       V | 32'd6},
    {16'h0034, 32'd0,       V | 32'd2},
    {16'h4080, V | 32'd14,  32'd0},
    {16'h8020, 32'd0,       V | 32'd15},
    {16'hFFFF, V | 32'd3,   V | 32'd6}
  };

  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [15:0] src_active = '0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        fast_irq, norm_irq;
  int checks = 0, errors = 0;

  chan_prio_router uut (.clk(clk), .rst_n(rst_n), .src_active(src_active),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fast_irq(fast_irq), .norm_irq(norm_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1; reg_addr = 6'(addr); reg_wdata = data;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    reg_addr = 6'(addr);
    #1 data = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int n = 0; n < 4; n++) begin rd(16 + n, d); check("R1 map reset", d, 32'h0F0F0F0F); end
    rd(0, d); check("R1 global en", d, 0);
    rd(5, d); check("R1 host en", d, 0);
    rd(3, d); check("R1 fast winner", d, 0);
    rd(4, d); check("R1 norm winner", d, 0);
    check("R1 irq lines", {30'd0, norm_irq, fast_irq}, 0);

    // R2 program map: s1=1,s2=5,s3=0,s4=5,s5=31,s6=2,s7=1,s8=0,s12=2,s14=0xE0(ch0)
    wr(16, 32'h0005010F); wr(17, 32'h01021F05);
    wr(18, 32'h0F0F0F00); wr(19, 32'h0FE00F02);
    rd(19, d); check("R2 map readback", d, 32'h0FE00F02);
    rd(17, d); check("R2 map readback", d, 32'h01021F05);

    // R7 / R6 enables
    wr(0, 1); rd(0, d); check("R7 global readback", d, 1);
    wr(1, 0); wr(1, 1); rd(5, d); check("R6 both set", d, 3);

    // table: R3 R4 R5 winners, R8 lines one edge later
    foreach (VEC[i]) begin
      @(negedge clk);
      src_active = VEC[i][79:64];
      rd(3, d); check("R3/R4/R5 fast winner", d, VEC[i][63:32]);
      rd(4, d); check("R3/R4/R5 norm winner", d, VEC[i][31:0]);
      @(negedge clk);
      check("R8 fast_irq", {31'd0, fast_irq}, {31'd0, VEC[i][63]});
      check("R8 norm_irq", {31'd0, norm_irq}, {31'd0, VEC[i][31]});
    end

    // R6 bad index ignored
    wr(2, 7); wr(1, 9); rd(5, d); check("R6 bad index", d, 3);
    // R6 clear fast only
    src_active = 16'h0009;  // s0 ch15, s3 ch0
    wr(2, 0); rd(5, d); check("R6 clear fast", d, 2);
    @(negedge clk);
    check("R8 fast disabled", {31'd0, fast_irq}, 0);
    check("R8 norm still on", {31'd0, norm_irq}, 1);
    rd(3, d); check("R5 winner kept while disabled", d, V | 32'd3);
    // R8 global off drops both
    wr(1, 0); wr(0, 0);
    @(negedge clk);
    check("R8 global off", {30'd0, norm_irq, fast_irq}, 0);
    // R8 clear normal then global on: only fast
    wr(2, 1); wr(0, 1);
    @(negedge clk);
    check("R8 only fast", {30'd0, norm_irq, fast_irq}, 1);

    // R9 unmapped address
    wr(40, 32'hFFFF_FFFF); rd(40, d); check("R9 unmapped read", d, 0);
    rd(5, d);  check("R9 enables unchanged", d, 1);
    rd(16, d); check("R9 map unchanged", d, 32'h0005010F);
    rd(0, d);  check("R9 global unchanged", d, 1);

    // R1 reset again mid-run
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(19, d); check("R1 map after reset", d, 32'h0F0F0F0F);
    check("R1 lines after reset", {30'd0, norm_irq, fast_irq}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule